// File: doc/BRIEF.md
# Double-Buffered SPI Configuration Register Port

This block is an SPI slave that lets a host processor read and write a small space of configuration registers with 12-bit addresses. Each transaction opens with a 16-bit instruction word carrying the direction, a byte count and the address. One to three data bytes follow, most significant byte first. The serial clock and chip select are brought into the system clock domain through synchronizers. Data is sampled on rising serial clock edges.

Configuration writes land in a staged bank. The active bank drives the `active_cfg` output, and it changes only when the host sets the update bit. A readback-select bit picks whether reads show the staged or the active copy. A port-control register chooses where read data leaves the block: on a dedicated output pin (4-wire) or on the shared data line with an output enable (3-wire). The same register has a soft-reset bit. A version register and a part identifier register are read-only constants.

The transaction state machine has five states:
- IDLE: chip select is inactive.
- INSTR: shifting in the instruction. The machine enters it from IDLE when chip select becomes active.
- WDATA or RDATA: the data phase. At the 16th bit the machine moves to RDATA when instruction bit 15 is 1, and to WDATA when it is 0.
- HOLD: entered from either data state after the last data bit. It waits there for the deselect.

Chip select going inactive returns the machine to IDLE from any state.

Top module: `spi_cfg_regport`

## Requirements
- R1: The instruction word is 16 bits and arrives MSB first on `sdio_in`. It is sampled on rising `sclk` edges while `cs_n` is low. Bit 15 is 1 for a read and 0 for a write. Bits 14:13 give the byte count minus one; code 3 is treated as 3 bytes. Bit 12 is ignored, and bits 11:0 are the address.
- R2: An N-byte write stores its data bytes right-aligned and zero-extended to 24 bits. An N-byte read returns the low 8·N bits of the register, MSB first.
- R3: Configuration registers 0x010 to 0x013 are written into the staged bank; the active bank, and with it `active_cfg` (register k at bits 24k+23:24k), stays unchanged. Writing 1 to bit 0 of address 0x234 copies every staged register into the active bank on the next clock. The update bit clears on that same edge and reads back as 0.
- R4: Bit 0 of address 0x004 selects the read source for configuration registers. When it is 1, reads return the staged value. When it is 0, reads return the active value. It resets to 0.
- R5: If `cs_n` rises before the last data bit of a write, no register changes.
- R6: Writes to unimplemented addresses change nothing, and reads from them return zero.
- R7: Address 0x002 returns the VERSION parameter and address 0x003 returns the PART_ID parameter. Writes to either address are ignored.
- R8: Bit 7 of address 0x000 controls the read output, and it resets to 0. When it is 1, read data goes out on `sdo` and `sdio_oe` stays low. When it is 0, read data goes out on `sdio_out`, and `sdio_oe` is high only during the read data phase. An output that is not in use is held at 0.
- R9: Writing 1 to bit 5 of address 0x000 returns every register to its reset value: both banks, the read source select, the output mode and the update bit. Bit 5 itself reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host (idle low) |
| cs_n | input | 1 | Active-low chip select |
| sdio_in | input | 1 | Serial data from the host |
| sdio_out | output | 1 | Read data on the shared line in 3-wire mode |
| sdio_oe | output | 1 | Output enable for the shared data line |
| sdo | output | 1 | Read data in 4-wire mode |
| active_cfg | output | NUM_CFG*24 | Active copies of all configuration registers |

## Verification
After the host's last write bit, the write commits one clock after the synchronized rising edge is detected, which is about four system clocks after the pin edge. An update copies the staged values on the clock after that commit. Each read data bit changes a few clocks after a serial clock rise and holds until the next rise, so the monitor samples read data at the host's own rising edge. The bench checks `active_cfg` only after several idle clocks following chip-select deassertion, which is well past every register stage on the way.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int ADDR_W    = 12;
    localparam int INSTR_W   = 16;
    localparam int BYTE_W    = 8;

    localparam logic [ADDR_W-1:0] A_PORT  = 12'h000;
    localparam logic [ADDR_W-1:0] A_VER   = 12'h002;
    localparam logic [ADDR_W-1:0] A_PART  = 12'h003;
    localparam logic [ADDR_W-1:0] A_RBCTL = 12'h004;
    localparam logic [ADDR_W-1:0] A_UPD   = 12'h234;

    localparam int PORT_SDO_BIT = 7;
    localparam int PORT_RST_BIT = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_WDATA,
        ST_RDATA,
        ST_HOLD
    } xfer_state_t;

    function automatic logic [1:0] byte_count(input logic [1:0] code);
        return (code == 2'd3) ? 2'd3 : code + 2'd1;
    endfunction

endpackage

// File: rtl/spi_sync_front.sv
module spi_sync_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic cs_act,
    output logic mosi_s
);
    localparam int TAP = SYNC_STAGES - 1;

    logic [SYNC_STAGES:0]   sclk_q;
    logic [SYNC_STAGES-1:0] cs_q;
    logic [SYNC_STAGES-1:0] mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[SYNC_STAGES-1:0], sclk};
            cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
        end
    end

    assign sclk_rise = sclk_q[TAP] & ~sclk_q[TAP+1];
    assign cs_act    = ~cs_q[TAP];
    assign mosi_s    = mosi_q[TAP];

endmodule

// File: rtl/spi_xfer_fsm.sv
module spi_xfer_fsm
    import spi_regport_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              cs_act,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_phase,
    output logic              tx_bit
);
    localparam int MAX_BYTES = DATA_W / BYTE_W;
    localparam int CNT_W     = $clog2((DATA_W > INSTR_W) ? DATA_W : INSTR_W);

    xfer_state_t        state, nxt;
    logic [INSTR_W-1:0] sh_in;
    logic [INSTR_W-1:0] instr_full;
    logic [CNT_W-1:0]   bit_cnt;
    logic [CNT_W-1:0]   last_bit;
    logic [1:0]         len_q;
    logic               tx_load;
    logic [DATA_W-1:0]  tx_sh;
    logic [DATA_W-1:0]  wr_sh;

    assign instr_full = {sh_in[INSTR_W-2:0], mosi_s};
    assign last_bit   = CNT_W'({len_q, 3'b000}) - CNT_W'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (cs_act) nxt = ST_INSTR;
            ST_INSTR: begin
                if (!cs_act) nxt = ST_IDLE;
                else if (sclk_rise && bit_cnt == CNT_W'(INSTR_W-1))
                    nxt = instr_full[INSTR_W-1] ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA, ST_RDATA: begin
                if (!cs_act) nxt = ST_IDLE;
                else if (sclk_rise && bit_cnt == last_bit) nxt = ST_HOLD;
            end
            ST_HOLD:  if (!cs_act) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_in   <= '0;
            bit_cnt <= '0;
            len_q   <= 2'd1;
            addr    <= '0;
            wr_sh   <= '0;
            wr_data <= '0;
            wr_en   <= 1'b0;
            tx_sh   <= '0;
            tx_load <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            tx_load <= 1'b0;
            if (tx_load)
                tx_sh <= rd_data << (BYTE_W * (MAX_BYTES - int'(len_q)));
            unique case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                end
                ST_INSTR: if (cs_act && sclk_rise) begin
                    sh_in <= instr_full;
                    if (bit_cnt == CNT_W'(INSTR_W-1)) begin
                        bit_cnt <= '0;
                        len_q   <= byte_count(instr_full[14:13]);
                        addr    <= instr_full[ADDR_W-1:0];
                        wr_sh   <= '0;
                        tx_load <= instr_full[INSTR_W-1];
                    end else begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
                ST_WDATA: if (cs_act && sclk_rise) begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                    wr_sh   <= {wr_sh[DATA_W-2:0], mosi_s};
                    if (bit_cnt == last_bit) begin
                        wr_data <= {wr_sh[DATA_W-2:0], mosi_s};
                        wr_en   <= 1'b1;
                    end
                end
                ST_RDATA: if (cs_act && sclk_rise) begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                    tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
                end
                ST_HOLD: ;
                default: ;
            endcase
        end
    end

    assign rd_phase = (state == ST_RDATA);
    assign tx_bit   = tx_sh[DATA_W-1];

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_regport_pkg::*;
#(
    parameter int                NUM_CFG  = 4,
    parameter int                DATA_W   = 24,
    parameter logic [ADDR_W-1:0] CFG_BASE = 12'h010,
    parameter logic [7:0]        VERSION  = 8'h01,
    parameter logic [7:0]        PART_ID  = 8'hA5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [DATA_W-1:0]         rd_data,
    output logic [NUM_CFG*DATA_W-1:0] active_flat,
    output logic                      sdo_en,
    output logic                      upd_pend,
    output logic                      soft_rst
);
    logic [DATA_W-1:0] staged [NUM_CFG];
    logic [DATA_W-1:0] active [NUM_CFG];
    logic              rb_sel;

    assign soft_rst = wr_en && (addr == A_PORT) && wr_data[PORT_RST_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CFG; i++) begin
                staged[i] <= '0;
                active[i] <= '0;
            end
            sdo_en   <= 1'b0;
            rb_sel   <= 1'b0;
            upd_pend <= 1'b0;
        end else if (soft_rst) begin
            for (int i = 0; i < NUM_CFG; i++) begin
                staged[i] <= '0;
                active[i] <= '0;
            end
            sdo_en   <= 1'b0;
            rb_sel   <= 1'b0;
            upd_pend <= 1'b0;
        end else begin
            if (upd_pend) begin
                for (int i = 0; i < NUM_CFG; i++) active[i] <= staged[i];
                upd_pend <= 1'b0;
            end
            if (wr_en) begin
                if (addr == A_PORT)  sdo_en   <= wr_data[PORT_SDO_BIT];
                if (addr == A_RBCTL) rb_sel   <= wr_data[0];
                if (addr == A_UPD)   upd_pend <= wr_data[0];
                for (int i = 0; i < NUM_CFG; i++)
                    if (addr == CFG_BASE + ADDR_W'(i)) staged[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == A_PORT)  rd_data = DATA_W'({sdo_en, 7'b0});
        if (addr == A_VER)   rd_data = DATA_W'(VERSION);
        if (addr == A_PART)  rd_data = DATA_W'(PART_ID);
        if (addr == A_RBCTL) rd_data = DATA_W'(rb_sel);
        if (addr == A_UPD)   rd_data = DATA_W'(upd_pend);
        for (int i = 0; i < NUM_CFG; i++)
            if (addr == CFG_BASE + ADDR_W'(i))
                rd_data = rb_sel ? staged[i] : active[i];
    end

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_flat
        assign active_flat[g*DATA_W +: DATA_W] = active[g];
    end

endmodule

// File: rtl/spi_cfg_regport.sv
module spi_cfg_regport
    import spi_regport_pkg::*;
#(
    parameter int                NUM_CFG     = 4,
    parameter int                DATA_W      = 24,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] CFG_BASE    = 12'h010,
    parameter logic [7:0]        VERSION     = 8'h01,
    parameter logic [7:0]        PART_ID     = 8'hA5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sclk,
    input  logic                      cs_n,
    input  logic                      sdio_in,
    output logic                      sdio_out,
    output logic                      sdio_oe,
    output logic                      sdo,
    output logic [NUM_CFG*DATA_W-1:0] active_cfg
);
    logic              sclk_rise;
    logic              cs_act;
    logic              mosi_s;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic              rd_phase;
    logic              tx_bit;
    logic              sdo_en;
    logic              upd_pend;
    logic              soft_rst;
    logic              drive;

    spi_sync_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .mosi     (sdio_in),
        .sclk_rise(sclk_rise),
        .cs_act   (cs_act),
        .mosi_s   (mosi_s)
    );

    spi_xfer_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_rise(sclk_rise),
        .cs_act   (cs_act),
        .mosi_s   (mosi_s),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_phase (rd_phase),
        .tx_bit   (tx_bit)
    );

    spi_reg_bank #(
        .NUM_CFG (NUM_CFG),
        .DATA_W  (DATA_W),
        .CFG_BASE(CFG_BASE),
        .VERSION (VERSION),
        .PART_ID (PART_ID)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .active_flat(active_cfg),
        .sdo_en     (sdo_en),
        .upd_pend   (upd_pend),
        .soft_rst   (soft_rst)
    );

    assign drive    = rd_phase && cs_act;
    assign sdio_oe  = drive && !sdo_en;
    assign sdio_out = sdio_oe ? tx_bit : 1'b0;
    assign sdo      = (drive && sdo_en) ? tx_bit : 1'b0;

endmodule

// File: rtl/spi_cfg_regport_chk.sv
module spi_cfg_regport_chk #(
    parameter int CFG_W = 96
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_act,
    input logic             wr_en,
    input logic             upd_pend,
    input logic             soft_rst,
    input logic             sdio_oe,
    input logic             sdo,
    input logic [CFG_W-1:0] active_cfg
);
    // R5: a commit only happens inside a selected frame
    a_r5_commit_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> cs_act);

    // R2: each write transaction commits once
    a_r2_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R3: update bit lasts a single cycle
    a_r3_update_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pend |=> !upd_pend);

    // R3: active bank moves only on update or soft reset
    a_r3_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_pend && !soft_rst) |=> $stable(active_cfg));

    // R8: shared line driven only while selected
    a_r8_oe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> cs_act);

    // R8: dedicated output quiet while shared line drives
    a_r8_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> !sdo);

endmodule

bind spi_cfg_regport spi_cfg_regport_chk #(.CFG_W(NUM_CFG*DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .wr_en     (wr_en),
    .upd_pend  (upd_pend),
    .soft_rst  (soft_rst),
    .sdio_oe   (sdio_oe),
    .sdo       (sdo),
    .active_cfg(active_cfg)
);

// File: tb/spi_cfg_regport_tb_top.sv
module spi_cfg_regport_tb_top;

    localparam int NUM_CFG = 4;
    localparam int DW      = 24;
    localparam logic [7:0] VER  = 8'h01;
    localparam logic [7:0] PART = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdo;
    logic [NUM_CFG*DW-1:0] active_cfg;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [23:0] val;
        bit          via_sdio;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    spi_cfg_regport dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdio_in   (sdio_in),
        .sdio_out  (sdio_out),
        .sdio_oe   (sdio_oe),
        .sdo       (sdo),
        .active_cfg(active_cfg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_active(input string req, input logic [23:0] e0, input logic [23:0] e1,
                                input logic [23:0] e2, input logic [23:0] e3);
        check({req, " reg0"}, 32'(active_cfg[0 +: DW]),  32'(e0));
        check({req, " reg1"}, 32'(active_cfg[24 +: DW]), 32'(e1));
        check({req, " reg2"}, 32'(active_cfg[48 +: DW]), 32'(e2));
        check({req, " reg3"}, 32'(active_cfg[72 +: DW]), 32'(e3));
    endtask

    // driver: one SPI frame, optional early deselect after stop_bits
    task automatic spi_frame(input bit rd, input int nb, input logic [11:0] a,
                             input logic [23:0] wd, input int stop_bits);
        logic [15:0] instr;
        int total;
        instr = {rd, 2'(nb - 1), 1'b0, a};
        total = 16 + 8 * nb;
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int b = 0; b < total; b++) begin
            if (stop_bits >= 0 && b >= stop_bits) break;
            if (b < 16) sdio_in = instr[15 - b];
            else        sdio_in = rd ? 1'b0 : wd[8 * nb - 1 - (b - 16)];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic spi_wr(input int nb, input logic [11:0] a, input logic [23:0] wd);
        spi_frame(1'b0, nb, a, wd, -1);
    endtask

    task automatic spi_rd(input int nb, input logic [11:0] a, input logic [23:0] expv,
                          input bit via_sdio, input string req);
        exp_t e;
        e.val = expv & ((24'h1 << (8 * nb)) - 24'h1);
        if (nb == 3) e.val = expv;
        e.via_sdio = via_sdio;
        e.req = req;
        exp_q.push_back(e);
        spi_frame(1'b1, nb, a, 24'h0, -1);
    endtask

    // monitor: decodes frames on the pins and compares reads
    int          mon_cnt = 0;
    logic [15:0] mon_instr = '0;
    logic [23:0] mon_data = '0;
    bit          mon_oe = 1'b0;

    always @(posedge sclk) begin
        if (!cs_n) begin
            if (mon_cnt < 16) mon_instr = {mon_instr[14:0], sdio_in};
            else if (mon_instr[15]) begin
                if (mon_cnt == 16) mon_oe = sdio_oe;
                mon_data = {mon_data[22:0], (sdio_oe ? sdio_out : sdo)};
            end
            mon_cnt++;
        end
    end

    always @(posedge cs_n) begin
        int nb;
        exp_t e;
        nb = (mon_instr[14:13] == 2'd3) ? 3 : int'(mon_instr[14:13]) + 1;
        if (mon_instr[15] && mon_cnt == 16 + 8 * nb) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R1 unexpected read actual=%h expected=none", mon_data);
            end else begin
                e = exp_q.pop_front();
                check({e.req, " read data"}, 32'(mon_data), 32'(e.val));
                check("R8 read line select", 32'(mon_oe), 32'(e.via_sdio));
            end
        end
        mon_cnt = 0;
        mon_data = '0;
        mon_instr = '0;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state
        check_active("R3 reset", 24'h0, 24'h0, 24'h0, 24'h0);
        check("R8 reset oe", 32'(sdio_oe), 32'h0);
        check("R8 reset sdo", 32'(sdo), 32'h0);

        // R3: write goes to staged only
        spi_wr(3, 12'h010, 24'h123456);
        check_active("R3 staged only", 24'h0, 24'h0, 24'h0, 24'h0);
        // R4: select 0 reads active
        spi_rd(3, 12'h010, 24'h000000, 1'b1, "R4 active read");
        // R4: select 1 reads staged
        spi_wr(1, 12'h004, 24'h01);
        spi_rd(3, 12'h010, 24'h123456, 1'b1, "R4 staged read");
        spi_rd(1, 12'h004, 24'h01, 1'b1, "R4 select readback");
        // R2: two-byte write zero-extends
        spi_wr(2, 12'h011, 24'hBEEF);
        spi_rd(3, 12'h011, 24'h00BEEF, 1'b1, "R2 zero extend");
        // R3: update
        spi_wr(1, 12'h234, 24'h01);
        check_active("R3 after update", 24'h123456, 24'h00BEEF, 24'h0, 24'h0);
        spi_rd(1, 12'h234, 24'h00, 1'b1, "R3 update bit clear");
        // R2: truncated reads of active copy
        spi_wr(1, 12'h004, 24'h00);
        spi_rd(1, 12'h011, 24'h0000EF, 1'b1, "R2 one byte");
        spi_rd(2, 12'h010, 24'h003456, 1'b1, "R2 two bytes");
        // R5: aborted write
        spi_wr(1, 12'h012, 24'h77);
        spi_frame(1'b0, 3, 12'h010, 24'hABCDEF, 28);
        spi_wr(1, 12'h234, 24'h01);
        check_active("R5 abort", 24'h123456, 24'h00BEEF, 24'h000077, 24'h0);
        // R6: unimplemented address
        spi_wr(1, 12'h3FF, 24'hFF);
        spi_rd(1, 12'h3FF, 24'h00, 1'b1, "R6 unimplemented read");
        spi_wr(1, 12'h234, 24'h01);
        check_active("R6 no side effect", 24'h123456, 24'h00BEEF, 24'h000077, 24'h0);
        // R7: read-only identifiers
        spi_rd(1, 12'h002, 24'(VER), 1'b1, "R7 version");
        spi_rd(1, 12'h003, 24'(PART), 1'b1, "R7 part");
        spi_wr(1, 12'h002, 24'h5A);
        spi_wr(1, 12'h003, 24'h5A);
        spi_rd(1, 12'h002, 24'(VER), 1'b1, "R7 version after write");
        spi_rd(1, 12'h003, 24'(PART), 1'b1, "R7 part after write");
        // R8: four-wire mode
        spi_wr(1, 12'h000, 24'h80);
        spi_rd(3, 12'h010, 24'h123456, 1'b0, "R8 sdo read");
        spi_rd(1, 12'h000, 24'h80, 1'b0, "R8 mode readback");
        // R9: soft reset
        spi_wr(1, 12'h000, 24'h20);
        check_active("R9 soft reset", 24'h0, 24'h0, 24'h0, 24'h0);
        spi_rd(1, 12'h000, 24'h00, 1'b1, "R9 port reg");
        spi_rd(1, 12'h004, 24'h00, 1'b1, "R9 select reg");
        // R1: full frame decode after reset, code 2 = 3 bytes
        spi_wr(3, 12'h013, 24'hC3A5F0);
        spi_wr(1, 12'h234, 24'h01);
        check_active("R1 decode", 24'h0, 24'h0, 24'h0, 24'hC3A5F0);
        spi_rd(3, 12'h013, 24'hC3A5F0, 1'b1, "R1 readback");

        repeat (10) @(negedge clk);
        check("R1 all reads seen", 32'(exp_q.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule